// File: doc/BRIEF.md
# Limit-Bounded Ramp Generator with Snap-Back Modes

This block is a synchronous ramp accumulator. It steps an unsigned output between a programmed floor and ceiling. Each direction has its own step size and its own step interval. A single control input selects the ramp direction or triggers a ramp. Two wrap bits decide what happens when the output arrives at a limit:

- **Both bits clear:** the output parks at the limit.
- **Top-wrap bit set:** after reaching the ceiling the output jumps straight back to the floor. A rising control edge then fires one upward sweep.
- **Bottom-wrap bit set:** the mirror of top-wrap. A falling edge fires one downward sweep, and reaching the floor jumps the output to the ceiling.
- **Both bits set:** the output sweeps back and forth without stopping. Control edges only reverse the sweep.

All settings arrive on shadow inputs. They become active only in the cycle after the update strobe `upd_i`. A limit flag reports that the output is sitting at either limit. In the back-and-forth mode, the flag instead gives a short pulse each time a limit is reached.

Top module: `ramp_gen`

## Requirements
- R1: After reset `ramp_o` is 0, `at_lim_o` is 0, and all active settings are cleared, so the ramp is disabled.
- R2: Shadow settings take effect only in the cycle after a clock edge at which `upd_i` is 1. Changing them without the strobe leaves `ramp_o` unchanged.
- R3: While moving, `ramp_o` changes once every interval+1 cycles of the current direction. A direction change spends one cycle restarting the interval count, and the first step follows interval+1 cycles later.
- R4: With both wrap bits clear, control level 1 ramps up and level 0 ramps down. A limit, once reached, is held while the level stays the same.
- R5: A step that would reach or cross a limit lands exactly on that limit, and this counts as reaching it.
- R6: With only the top-wrap bit set (mode bits {bottom, top} = 01), reaching the ceiling sets `ramp_o` to the floor on that same edge. The output then idles until the next rising control edge, which starts an upward sweep.
- R7: In either single-sweep mode, the control level and any edges seen during a sweep have no effect until the sweep reaches its limit.
- R8: With only the bottom-wrap bit set (mode 10), a falling edge starts a downward sweep. Reaching the floor sets `ramp_o` to the ceiling, and the output idles there.
- R9: With both bits set (mode 11), `ramp_o` reverses direction at each limit and keeps sweeping, using the step and interval of the new direction.
- R10: In mode 11, a falling edge during an upward sweep, or a rising edge during a downward sweep, reverses the direction at once. An edge that agrees with the current direction has no effect.
- R11: In modes 00, 01 and 10 with the flag enabled, `at_lim_o` is 1 exactly when `ramp_o` equals the floor or the ceiling.
- R12: In mode 11 with the flag enabled, `at_lim_o` is 1 for the two cycles after each edge at which a limit is reached.
- R13: With the flag enable cleared, `at_lim_o` is 0.
- R14: With the ramp disabled, `ramp_o` holds its value, and any single sweep in progress is cancelled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| upd_i | input | 1 | Copies the shadow settings into the active registers |
| cfg_en_i | input | 1 | Shadow ramp enable |
| wrap_top_i | input | 1 | Shadow top-wrap bit (ceiling snaps to floor) |
| wrap_bot_i | input | 1 | Shadow bottom-wrap bit (floor snaps to ceiling) |
| flag_en_i | input | 1 | Shadow enable for `at_lim_o` |
| floor_i | input | W | Shadow lower limit |
| ceil_i | input | W | Shadow upper limit |
| up_step_i | input | W | Shadow upward step size |
| dn_step_i | input | W | Shadow downward step size |
| up_ivl_i | input | IW | Shadow upward interval (cycles between steps minus one) |
| dn_ivl_i | input | IW | Shadow downward interval |
| dir_ctl_i | input | 1 | Direction or trigger control |
| ramp_o | output | W | Ramp value |
| at_lim_o | output | 1 | Limit flag |

## Verification
The bench goes after these corner cases:

- **Clamping:** steps that do not divide the span evenly. A design without clamping would overshoot the ceiling or wrap the accumulator past it.
- **Snap-back:** a design that ramps back down instead of jumping would show intermediate values after the ceiling. A design that honours edges during a single sweep would restart or stall part way.
- **Reversal:** in the back-and-forth mode, an opposing edge must cost exactly one restart cycle, and an agreeing edge must cost none. A late or missing reversal shows up directly in the sampled values.
- **Flag timing:** a flag stretched past two cycles, or one that stays level-sensitive in the back-and-forth mode, differs from the cycle-by-cycle expectation.

The sweep covers each mode, interval and step size, with several toggle rates on the control input.

// File: rtl/ramp_pkg.sv
package ramp_pkg;
  typedef enum logic [1:0] {
    M_HOLD    = 2'b00,
    M_UP_SHOT = 2'b01,
    M_DN_SHOT = 2'b10,
    M_BOUNCE  = 2'b11
  } ramp_mode_e;

  localparam int unsigned PULSE_CYC = 2;
endpackage

// File: rtl/ramp_cfg.sv
module ramp_cfg import ramp_pkg::*; #(
  parameter int W  = 32,
  parameter int IW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          upd_i,
  input  logic          en_i,
  input  logic          wrap_top_i,
  input  logic          wrap_bot_i,
  input  logic          flag_en_i,
  input  logic [W-1:0]  floor_i,
  input  logic [W-1:0]  ceil_i,
  input  logic [W-1:0]  up_step_i,
  input  logic [W-1:0]  dn_step_i,
  input  logic [IW-1:0] up_ivl_i,
  input  logic [IW-1:0] dn_ivl_i,
  output logic          en_o,
  output ramp_mode_e    mode_o,
  output logic          flag_en_o,
  output logic [W-1:0]  floor_o,
  output logic [W-1:0]  ceil_o,
  output logic [W-1:0]  up_step_o,
  output logic [W-1:0]  dn_step_o,
  output logic [IW-1:0] up_ivl_o,
  output logic [IW-1:0] dn_ivl_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_o      <= 1'b0;
      mode_o    <= M_HOLD;
      flag_en_o <= 1'b0;
      floor_o   <= '0;
      ceil_o    <= '0;
      up_step_o <= '0;
      dn_step_o <= '0;
      up_ivl_o  <= '0;
      dn_ivl_o  <= '0;
    end else if (upd_i) begin
      en_o      <= en_i;
      mode_o    <= ramp_mode_e'({wrap_bot_i, wrap_top_i});
      flag_en_o <= flag_en_i;
      floor_o   <= floor_i;
      ceil_o    <= ceil_i;
      up_step_o <= up_step_i;
      dn_step_o <= dn_step_i;
      up_ivl_o  <= up_ivl_i;
      dn_ivl_o  <= dn_ivl_i;
    end
  end
endmodule

// File: rtl/ramp_ivl.sv
module ramp_ivl #(
  parameter int IW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic          dir_i,
  input  logic [IW-1:0] up_ivl_i,
  input  logic [IW-1:0] dn_ivl_i,
  output logic          tick_o
);
  localparam int NDIR = 2;

  logic [IW-1:0]   lim [NDIR];
  logic [NDIR-1:0] hit;

  assign lim[0] = dn_ivl_i;
  assign lim[1] = up_ivl_i;

  for (genvar d = 0; d < NDIR; d++) begin : g_dir
    logic [IW-1:0] cnt_q;
    logic          act;
    assign act    = run_i && (dir_i == 1'(d));
    assign hit[d] = act && (cnt_q == lim[d]);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)              cnt_q <= '0;
      else if (!act || hit[d])  cnt_q <= '0;
      else                      cnt_q <= cnt_q + IW'(1);
    end
  end

  assign tick_o = |hit;
endmodule

// File: rtl/ramp_core.sv
module ramp_core import ramp_pkg::*; #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         upd_i,
  input  logic         en_i,
  input  ramp_mode_e   mode_i,
  input  logic [W-1:0] floor_i,
  input  logic [W-1:0] ceil_i,
  input  logic [W-1:0] up_step_i,
  input  logic [W-1:0] dn_step_i,
  input  logic         ctl_i,
  input  logic         tick_i,
  output logic         run_o,
  output logic         dir_o,
  output logic         reach_o,
  output logic [W-1:0] ramp_o
);
  logic [W-1:0] acc_q, acc_n, up_room, dn_room;
  logic dir_q, run_q, ctl_q;
  logic dir_n, run_n, dir_s, run_s, restart, moving, step_go;
  logic rise, fall, hit_hi, hit_lo;

  assign rise = ctl_i & ~ctl_q;
  assign fall = ~ctl_i & ctl_q;

  // direction / trigger decision
  always_comb begin
    dir_n   = dir_q;
    run_n   = run_q;
    restart = 1'b0;
    unique case (mode_i)
      M_HOLD: begin
        dir_n   = ctl_i;
        restart = (ctl_i != dir_q);
      end
      M_UP_SHOT: if (!run_q && rise) begin
        run_n = 1'b1; dir_n = 1'b1; restart = 1'b1;
      end
      M_DN_SHOT: if (!run_q && fall) begin
        run_n = 1'b1; dir_n = 1'b0; restart = 1'b1;
      end
      M_BOUNCE: begin
        if (rise && !dir_q) begin
          dir_n = 1'b1; restart = 1'b1;
        end else if (fall && dir_q) begin
          dir_n = 1'b0; restart = 1'b1;
        end
      end
    endcase
  end

  assign moving  = (mode_i == M_HOLD) || (mode_i == M_BOUNCE) || run_q;
  assign run_o   = en_i && moving && !restart;
  assign step_go = run_o && tick_i;
  assign dir_o   = dir_q;

  assign up_room = ceil_i - acc_q;
  assign dn_room = acc_q - floor_i;
  assign hit_hi  = (acc_q >= ceil_i) || (up_step_i >= up_room);
  assign hit_lo  = (acc_q <= floor_i) || (dn_step_i >= dn_room);

  // step with clamp and wrap handling
  always_comb begin
    acc_n   = acc_q;
    dir_s   = dir_n;
    run_s   = run_n;
    reach_o = 1'b0;
    if (step_go) begin
      if (dir_q) begin
        if (hit_hi) begin
          reach_o = 1'b1;
          if (mode_i == M_UP_SHOT) begin
            acc_n = floor_i; run_s = 1'b0;
          end else begin
            acc_n = ceil_i;
          end
          if (mode_i == M_BOUNCE) dir_s = 1'b0;
        end else begin
          acc_n = acc_q + up_step_i;
        end
      end else begin
        if (hit_lo) begin
          reach_o = 1'b1;
          if (mode_i == M_DN_SHOT) begin
            acc_n = ceil_i; run_s = 1'b0;
          end else begin
            acc_n = floor_i;
          end
          if (mode_i == M_BOUNCE) dir_s = 1'b1;
        end else begin
          acc_n = acc_q - dn_step_i;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
      dir_q <= 1'b0;
      run_q <= 1'b0;
      ctl_q <= 1'b0;
    end else begin
      ctl_q <= ctl_i;
      if (en_i) begin
        acc_q <= acc_n;
        dir_q <= dir_s;
        run_q <= upd_i ? 1'b0 : run_s;
      end else begin
        run_q <= 1'b0;
      end
    end
  end

  assign ramp_o = acc_q;
endmodule

// File: rtl/ramp_flag.sv
module ramp_flag import ramp_pkg::*; #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         flag_en_i,
  input  ramp_mode_e   mode_i,
  input  logic         reach_i,
  input  logic [W-1:0] ramp_i,
  input  logic [W-1:0] floor_i,
  input  logic [W-1:0] ceil_i,
  output logic         at_lim_o
);
  localparam int PW = $clog2(PULSE_CYC + 1);

  logic [PW-1:0] pls_q;
  logic          bounce;

  assign bounce = (mode_i == M_BOUNCE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 pls_q <= '0;
    else if (reach_i && bounce)  pls_q <= PW'(PULSE_CYC);
    else if (pls_q != '0)        pls_q <= pls_q - PW'(1);
  end

  assign at_lim_o = flag_en_i &&
                    (bounce ? (pls_q != '0) : ((ramp_i == floor_i) || (ramp_i == ceil_i)));
endmodule

// File: rtl/ramp_gen.sv
module ramp_gen import ramp_pkg::*; #(
  parameter int W  = 32,
  parameter int IW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          upd_i,
  input  logic          cfg_en_i,
  input  logic          wrap_top_i,
  input  logic          wrap_bot_i,
  input  logic          flag_en_i,
  input  logic [W-1:0]  floor_i,
  input  logic [W-1:0]  ceil_i,
  input  logic [W-1:0]  up_step_i,
  input  logic [W-1:0]  dn_step_i,
  input  logic [IW-1:0] up_ivl_i,
  input  logic [IW-1:0] dn_ivl_i,
  input  logic          dir_ctl_i,
  output logic [W-1:0]  ramp_o,
  output logic          at_lim_o
);
  logic          en_q, flag_q;
  ramp_mode_e    mode_q;
  logic [W-1:0]  lo_q, hi_q, ustep_q, dstep_q;
  logic [IW-1:0] uivl_q, divl_q;
  logic          tick_w, ivl_run_w, dir_w, reach_w;

  ramp_cfg #(.W(W), .IW(IW)) u_cfg (
    .clk_i, .rst_ni, .upd_i,
    .en_i(cfg_en_i), .wrap_top_i, .wrap_bot_i, .flag_en_i,
    .floor_i, .ceil_i, .up_step_i, .dn_step_i, .up_ivl_i, .dn_ivl_i,
    .en_o(en_q), .mode_o(mode_q), .flag_en_o(flag_q),
    .floor_o(lo_q), .ceil_o(hi_q), .up_step_o(ustep_q), .dn_step_o(dstep_q),
    .up_ivl_o(uivl_q), .dn_ivl_o(divl_q)
  );

  ramp_ivl #(.IW(IW)) u_ivl (
    .clk_i, .rst_ni,
    .run_i(ivl_run_w), .dir_i(dir_w),
    .up_ivl_i(uivl_q), .dn_ivl_i(divl_q),
    .tick_o(tick_w)
  );

  ramp_core #(.W(W)) u_core (
    .clk_i, .rst_ni, .upd_i,
    .en_i(en_q), .mode_i(mode_q),
    .floor_i(lo_q), .ceil_i(hi_q), .up_step_i(ustep_q), .dn_step_i(dstep_q),
    .ctl_i(dir_ctl_i), .tick_i(tick_w),
    .run_o(ivl_run_w), .dir_o(dir_w), .reach_o(reach_w), .ramp_o(ramp_o)
  );

  ramp_flag #(.W(W)) u_flag (
    .clk_i, .rst_ni,
    .flag_en_i(flag_q), .mode_i(mode_q), .reach_i(reach_w),
    .ramp_i(ramp_o), .floor_i(lo_q), .ceil_i(hi_q),
    .at_lim_o(at_lim_o)
  );
endmodule

// File: rtl/ramp_gen_chk.sv
module ramp_gen_chk import ramp_pkg::*; #(
  parameter int W = 32
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         upd_i,
  input logic         ctl_i,
  input logic [W-1:0] ramp_o,
  input logic         at_lim_o,
  input logic         en_q,
  input logic         flag_q,
  input ramp_mode_e   mode_q,
  input logic [W-1:0] lo_q,
  input logic [W-1:0] hi_q,
  input logic         ivl_run_w,
  input logic         dir_w,
  input logic         reach_w
);
  p_active_cfg_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_i |=> $stable({en_q, flag_q, mode_q, lo_q, hi_q}));

  p_park_top_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_q && mode_q == M_HOLD && !upd_i && ctl_i && dir_w && ramp_o == hi_q)
    |=> ramp_o == $past(ramp_o));

  p_snap_floor_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_q && mode_q == M_UP_SHOT && !upd_i && reach_w && dir_w)
    |=> ramp_o == $past(lo_q));

  p_shot_monotone_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_q && mode_q == M_UP_SHOT && ivl_run_w && !upd_i)
    |=> (ramp_o >= $past(ramp_o)) || (ramp_o == $past(lo_q)));

  p_bounce_inside_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_q && mode_q == M_BOUNCE && !upd_i && lo_q <= hi_q && ramp_o >= lo_q && ramp_o <= hi_q)
    |=> (ramp_o >= lo_q) && (ramp_o <= hi_q));

  p_pulse_two_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_q && mode_q == M_BOUNCE && !upd_i && $rose(at_lim_o)) |=> at_lim_o);

  p_flag_off_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!flag_q && !upd_i) |=> !at_lim_o);

  p_frozen_r14: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_q && !upd_i) |=> $stable(ramp_o));
endmodule

bind ramp_gen ramp_gen_chk #(.W(W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .upd_i(upd_i), .ctl_i(dir_ctl_i),
  .ramp_o(ramp_o), .at_lim_o(at_lim_o),
  .en_q(en_q), .flag_q(flag_q), .mode_q(mode_q), .lo_q(lo_q), .hi_q(hi_q),
  .ivl_run_w(ivl_run_w), .dir_w(dir_w), .reach_w(reach_w)
);

// File: tb/ramp_gen_test.sv
`timescale 1ns/1ps
module ramp_gen_test;
  localparam int W  = 32;
  localparam int IW = 16;

  logic clk = 1'b0, rst_n = 1'b0, upd = 1'b0, en = 1'b0;
  logic wt = 1'b0, wb = 1'b0, fe = 1'b0, ctl = 1'b0;
  logic [W-1:0]  lo = '0, hi = '0, us = '0, ds = '0;
  logic [IW-1:0] ui = '0, di = '0;
  logic [W-1:0]  ramp;
  logic          flag;

  int checks = 0, fails = 0;
  bit done = 0, live = 0;

  always #2.5 clk = ~clk;

  ramp_gen #(.W(W), .IW(IW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .upd_i(upd),
    .cfg_en_i(en), .wrap_top_i(wt), .wrap_bot_i(wb), .flag_en_i(fe),
    .floor_i(lo), .ceil_i(hi), .up_step_i(us), .dn_step_i(ds),
    .up_ivl_i(ui), .dn_ivl_i(di), .dir_ctl_i(ctl),
    .ramp_o(ramp), .at_lim_o(flag)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // cycle model built from the requirements
  logic [W-1:0] e_acc = '0, e_lo = '0, e_hi = '0, e_us = '0, e_ds = '0;
  bit e_dir = 0, e_run = 0, e_ctl = 0, e_en = 0, e_wt = 0, e_wb = 0, e_fe = 0;
  int e_ph = 0, e_pls = 0, e_ui = 0, e_di = 0;

  always @(posedge clk or negedge rst_n) begin
    bit rs, fl, flip, hit, mv;
    logic [1:0] m;
    if (!rst_n) begin
      e_acc = '0; e_lo = '0; e_hi = '0; e_us = '0; e_ds = '0;
      e_dir = 0; e_run = 0; e_ctl = 0; e_en = 0; e_wt = 0; e_wb = 0; e_fe = 0;
      e_ph = 0; e_pls = 0; e_ui = 0; e_di = 0;
    end else begin
      m = {e_wb, e_wt};
      rs = ctl && !e_ctl;
      fl = !ctl && e_ctl;
      flip = 0; hit = 0;
      if (e_en) begin
        case (m)
          2'b00: if (ctl != e_dir) begin e_dir = ctl; flip = 1; end
          2'b01: if (!e_run && rs) begin e_run = 1; e_dir = 1; flip = 1; end
          2'b10: if (!e_run && fl) begin e_run = 1; e_dir = 0; flip = 1; end
          default: begin
            if (rs && !e_dir) begin e_dir = 1; flip = 1; end
            else if (fl && e_dir) begin e_dir = 0; flip = 1; end
          end
        endcase
        mv = (m == 2'b00) || (m == 2'b11) || e_run;
        if (flip || !mv) e_ph = 0;
        else if (e_ph == (e_dir ? e_ui : e_di)) begin
          e_ph = 0;
          if (e_dir) begin
            if ({1'b0, e_acc} + {1'b0, e_us} >= {1'b0, e_hi}) begin
              hit = 1;
              if (m == 2'b01) begin e_acc = e_lo; e_run = 0; end else e_acc = e_hi;
              if (m == 2'b11) e_dir = 0;
            end else e_acc = e_acc + e_us;
          end else begin
            if ({1'b0, e_acc} <= {1'b0, e_lo} + {1'b0, e_ds}) begin
              hit = 1;
              if (m == 2'b10) begin e_acc = e_hi; e_run = 0; end else e_acc = e_lo;
              if (m == 2'b11) e_dir = 1;
            end else e_acc = e_acc - e_ds;
          end
        end else e_ph++;
        if (upd) e_run = 0;
      end else begin
        e_ph = 0; e_run = 0;
      end
      if (hit && m == 2'b11) e_pls = 2;
      else if (e_pls > 0) e_pls--;
      e_ctl = ctl;
      if (upd) begin
        e_en = en; e_wt = wt; e_wb = wb; e_fe = fe;
        e_lo = lo; e_hi = hi; e_us = us; e_ds = ds;
        e_ui = int'(ui); e_di = int'(di);
      end
    end
  end

  always @(negedge clk) begin
    logic [1:0] m;
    bit ef;
    string tr, tf;
    if (live) begin
      m = {e_wb, e_wt};
      case (m)
        2'b00: tr = "R4 ramp (mode 00)";
        2'b01: tr = "R6/R7 ramp (mode 01)";
        2'b10: tr = "R8 ramp (mode 10)";
        default: tr = "R9/R10 ramp (mode 11)";
      endcase
      if (!e_fe) begin ef = 0; tf = "R13 flag"; end
      else if (m == 2'b11) begin ef = (e_pls != 0); tf = "R12 flag"; end
      else begin ef = (e_acc == e_lo) || (e_acc == e_hi); tf = "R11 flag"; end
      chk(ramp == e_acc, tr, longint'(ramp), longint'(e_acc));
      chk(flag == ef, tf, longint'(flag), longint'(ef));
    end
  end

  task automatic pulse_upd();
    upd = 1'b1;
    @(negedge clk);
    upd = 1'b0;
  endtask

  task automatic run_case(input logic [1:0] md, input int iu, input int idn,
                          input int su, input bit fl, input int per);
    @(negedge clk);
    en = 1'b1; {wb, wt} = md; fe = fl;
    lo = W'(20); hi = W'(60); us = W'(su); ds = W'(su + 1);
    ui = IW'(iu); di = IW'(idn);
    pulse_upd();
    for (int c = 0; c < 150; c++) begin
      if (c % per == per - 1) ctl = ~ctl;
      @(negedge clk);
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++;
      $display("FAIL watchdog R1 actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ramp == '0, "R1 ramp after reset", longint'(ramp), 0);
    chk(flag == 1'b0, "R1 flag after reset", longint'(flag), 0);
    live = 1;

    // R2: shadow values alone do nothing
    en = 1'b1; ctl = 1'b1; lo = W'(0); hi = W'(98); us = W'(5); ds = W'(4);
    ui = IW'(0); di = IW'(0); fe = 1'b1;
    repeat (5) @(negedge clk);
    chk(ramp == '0, "R2 no strobe", longint'(ramp), 0);
    pulse_upd();
    repeat (4) @(negedge clk);
    chk(ramp == W'(15), "R3 restart then unit interval", longint'(ramp), 15);
    repeat (30) @(negedge clk);
    chk(ramp == W'(98), "R5 clamp to ceiling", longint'(ramp), 98);
    chk(flag == 1'b1, "R11 flag at ceiling", longint'(flag), 1);

    // R3: downward interval of 2 after a direction change
    ctl = 1'b0; di = IW'(2);
    pulse_upd();
    @(negedge clk);
    chk(ramp == W'(98), "R3 restart cycle", longint'(ramp), 98);
    @(negedge clk);
    chk(ramp == W'(98), "R3 counting", longint'(ramp), 98);
    @(negedge clk);
    chk(ramp == W'(94), "R3 first down step", longint'(ramp), 94);
    repeat (2) @(negedge clk);
    chk(ramp == W'(94), "R3 hold between steps", longint'(ramp), 94);
    @(negedge clk);
    chk(ramp == W'(90), "R3 second down step", longint'(ramp), 90);

    // R14: disable freezes output despite control activity
    en = 1'b0;
    pulse_upd();
    v = ramp;
    for (int k = 0; k < 10; k++) begin
      ctl = ~ctl;
      @(negedge clk);
    end
    chk(ramp == v, "R14 frozen while disabled", longint'(ramp), longint'(v));

    // sweep over modes, intervals and step sizes
    for (int md = 0; md < 4; md++)
      for (int iu = 0; iu < 3; iu++)
        for (int s = 0; s < 3; s++)
          run_case(2'(md), iu, (iu + 1) % 3, (s == 0) ? 1 : (s == 1) ? 3 : 7,
                   s != 1, 7 + 4 * iu + md);

    // R10: reversal in the back-and-forth mode
    ctl = 1'b0; en = 1'b1; {wb, wt} = 2'b11; fe = 1'b1;
    lo = W'(0); hi = W'(1000); us = W'(10); ds = W'(10); ui = IW'(0); di = IW'(0);
    pulse_upd();
    repeat (3) @(negedge clk);
    ctl = 1'b1;
    repeat (20) @(negedge clk);
    v = ramp;
    ctl = 1'b0;
    @(negedge clk);
    chk(ramp == v, "R10 reversal restart cycle", longint'(ramp), longint'(v));
    @(negedge clk);
    chk(ramp == v - W'(10), "R10 reversed to down", longint'(ramp), longint'(v - W'(10)));
    repeat (60) @(negedge clk);
    v = ramp;
    @(negedge clk);
    chk(ramp == v + W'(10), "R9 rising after floor bounce", longint'(ramp), longint'(v + W'(10)));
    v = ramp;
    ctl = 1'b1;
    @(negedge clk);
    chk(ramp == v + W'(10), "R10 agreeing edge ignored", longint'(ramp), longint'(v + W'(10)));

    repeat (5) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule